// File: doc/BRIEF.md
# Streaming Ones-Complement Checksum Unit

The block computes a 16-bit ones-complement checksum over a data unit. The data unit arrives as a stream of equal-width segments on a valid/ready input, and a last flag marks the final segment. One accumulator serves both ends of a link. In generate mode the block adds up the data segments. At the end of the unit it outputs the complement of the running total, which the sender appends to the unit as its checksum field.

In check mode the receiver streams the data segments followed by the received checksum field. The block adds all of them and complements the total. A zero result means the unit is intact and is accepted; any other value means it is rejected. Every addition folds the carry out of the top bit back into bit 0 in the same cycle, so the running sum never grows wider than one segment.

Top module: `csum_unit`

## Requirements
- R1: After reset, `resValid` is 0 and `inReady` is 1.
- R2: Each consumed segment is added to the running sum with ones-complement arithmetic. A carry out of the top bit is added back into bit 0 in the same cycle, and the sum always stays `SEG_W` bits wide.
- R3: When `modeCheck` is 0 on the final segment, `resWord` is the bitwise complement of the unit's sum, and `resAccept` is 0.
- R4: When `modeCheck` is 1 on the final segment, `resWord` is the complement of the sum of all segments, checksum field included. `resAccept` is 1 exactly when that value is zero.
- R5: `resValid` is high for exactly one cycle, in the cycle right after the segment with `inLast` = 1 is consumed.
- R6: A segment is consumed only when `inValid` and `inReady` are both high. `inReady` is low during the cycle in which `resValid` is high, and high in every other cycle.
- R7: The first segment consumed after reset or after a final segment starts a new sum from zero. Nothing from the previous unit carries over.
- R8: An all-ones sum and an all-zero sum stay distinct values. A check-mode unit whose segments sum to 16'hFFFF is accepted. A check-mode unit whose segments sum to 16'h0000 is rejected with `resWord` = 16'hFFFF.
- R9: The mode is taken from `modeCheck` in the cycle the final segment is consumed. Its value on earlier segments has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Segment present on `inData` |
| inReady | output | 1 | Block can take a segment this cycle |
| inData | input | SEG_W | Segment value |
| inLast | input | 1 | Segment is the last of its unit |
| modeCheck | input | 1 | 0 = generate checksum, 1 = verify unit |
| resValid | output | 1 | One-cycle result strobe |
| resWord | output | SEG_W | Checksum word (generate) or complemented total (check) |
| resAccept | output | 1 | Unit intact (check mode only) |

## Verification
The bench builds the block with its default segment width of 16. At that width the end-around carry fires often when segments are random. The width also lets the bench hit the exact 16'hFFFF and 16'h0000 totals that separate accept from reject. The stimulus mixes single-segment and multi-segment units, back-to-back units that land on the one-cycle ready bubble, idle gaps, and a mode input that toggles before the final segment. Round trips check, in check mode, a checksum that the bench itself generated, and a corrupted copy of the same unit must be rejected.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef struct packed {
    logic take;   // segment consumed this cycle
    logic first;  // consumed segment opens a new unit
    logic fin;    // consumed segment closes the unit
  } csumStrobes_t;
endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inLast,
  output logic         inReady,
  output logic         resValid,
  output csumStrobes_t strb
);
  logic startQ;
  logic resValidQ;

  assign inReady    = !resValidQ;
  assign strb.take  = inValid && inReady;
  assign strb.first = strb.take && startQ;
  assign strb.fin   = strb.take && inLast;
  assign resValid   = resValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ    <= 1'b1;
      resValidQ <= 1'b0;
    end else begin
      resValidQ <= strb.fin;
      if (strb.fin)       startQ <= 1'b1;
      else if (strb.take) startQ <= 1'b0;
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R5
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !strb.take); // R6
  AST_RESULT_AFTER_FIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.fin |=> resValid); // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.fin |=> (!strb.take || strb.first)); // R7
endmodule

// File: rtl/csum_dp.sv
module csum_dp
  import csum_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  csumStrobes_t     strb,
  input  logic [SEG_W-1:0] inData,
  input  logic             modeCheck,
  output logic [SEG_W-1:0] resWord,
  output logic             resAccept
);
  localparam int SUM_W = SEG_W + 1;

  logic [SEG_W-1:0] accQ;
  logic [SEG_W-1:0] base;
  logic [SUM_W-1:0] rawSum;
  logic [SEG_W-1:0] folded;
  logic [SEG_W-1:0] compl;

  assign base   = strb.first ? '0 : accQ;
  assign rawSum = {1'b0, base} + {1'b0, inData};
  // end-around carry; cannot carry a second time
  assign folded = rawSum[SEG_W-1:0] + {{(SEG_W-1){1'b0}}, rawSum[SEG_W]};
  assign compl  = ~folded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      resWord   <= '0;
      resAccept <= 1'b0;
    end else begin
      if (strb.take) accQ <= folded;
      if (strb.fin) begin
        resWord   <= compl;
        resAccept <= modeCheck && (compl == '0);
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> $stable(accQ)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fin |=> ($stable(resWord) && $stable(resAccept))); // R5
  AST_ACCEPT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    resAccept |-> (resWord == '0)); // R4
endmodule

// File: rtl/csum_unit.sv
module csum_unit
  import csum_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [SEG_W-1:0] inData,
  input  logic             inLast,
  input  logic             modeCheck,
  output logic             resValid,
  output logic [SEG_W-1:0] resWord,
  output logic             resAccept
);
  csumStrobes_t strb;

  csum_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inReady  (inReady),
    .resValid (resValid),
    .strb     (strb)
  );

  csum_dp #(.SEG_W(SEG_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inData    (inData),
    .modeCheck (modeCheck),
    .resWord   (resWord),
    .resAccept (resAccept)
  );

  AST_READY_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !inReady); // R6
endmodule

// File: tb/test_csum_unit.sv
module test_csum_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, modeCheck = 1'b0;
  logic [15:0] inData = '0;
  logic inReady, resValid, resAccept;
  logic [15:0] resWord;

  always #4 clk = ~clk; // 125 MHz

  csum_unit i_csum_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .modeCheck(modeCheck),
    .resValid(resValid), .resWord(resWord), .resAccept(resAccept));

  int nVec = 0, nFail = 0;
  // reference model state
  int  mAcc = 0;
  bit  mStart = 1;
  bit  mResValid = 0;
  int  mWord = 0;
  bit  mAccept = 0;

  function automatic int ocAdd(int a, int b);
    int s = a + b;
    if (s > 65535) s = s - 65535;
    return s;
  endfunction

  function automatic int unitSum(int q[$]);
    int s = 0;
    foreach (q[i]) s = ocAdd(s, q[i]);
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: compare ready now, step model, compare outputs after edge
  task automatic step(output bit taken);
    bit expReady = !mResValid;
    bit fire;
    int s;
    chk(inReady == expReady, "R6 ready", inReady, expReady);
    fire = inValid && expReady;
    taken = fire;
    mResValid = 0;
    if (fire) begin
      s = ocAdd(mStart ? 0 : mAcc, inData);   // R2 R7
      mAcc = s;
      if (inLast) begin
        mResValid = 1;
        mWord = (~s) & 16'hFFFF;
        mAccept = modeCheck && (mWord == 0);  // R9
        mStart = 1;
      end else mStart = 0;
    end
    @(posedge clk); @(negedge clk);
    chk(resValid == mResValid, "R5 resValid", resValid, mResValid);
    if (mResValid) begin
      chk(resWord == mWord[15:0], "R3/R4 resWord", resWord, mWord);
      chk(resAccept == mAccept, "R4 resAccept", resAccept, mAccept);
    end
  endtask

  task automatic idle(int n);
    bit t;
    inValid = 0;
    for (int i = 0; i < n; i++) step(t);
  endtask

  // send a unit; gaps inserted randomly; mode may toggle before last (R9)
  task automatic sendUnit(int q[$], bit mode, bit gaps, bit toggleMode);
    bit t;
    foreach (q[i]) begin
      if (gaps && ($urandom_range(0, 2) == 0)) idle($urandom_range(1, 2));
      inValid = 1; inData = q[i][15:0]; inLast = (i == q.size() - 1);
      modeCheck = (toggleMode && !inLast) ? !mode : mode;
      t = 0;
      while (!t) step(t);
      inValid = 0; inLast = 0;
    end
  endtask

  initial begin
    int q[$];
    int ck;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(resValid == 0, "R1 resValid", resValid, 0);
    chk(inReady == 1, "R1 inReady", inReady, 1);
    rstN = 1;
    @(negedge clk);
    idle(2);

    // R3 generate, carry-heavy segments (R2)
    q = '{16'hFFFE, 16'h8001, 16'h7FFF, 16'hC000};
    sendUnit(q, 0, 0, 0);
    // R4 round trip accept, back to back (R6 bubble, R7 restart)
    ck = (~unitSum(q)) & 16'hFFFF;
    q.push_back(ck);
    sendUnit(q, 1, 0, 0);
    // corrupted copy rejected
    q[1] = q[1] ^ 16'h0010;
    sendUnit(q, 1, 1, 0);
    // R8 single all-ones accepted, all-zero rejected with FFFF
    q = '{16'hFFFF}; sendUnit(q, 1, 0, 0);
    q = '{16'h0000}; sendUnit(q, 1, 0, 0);
    q = '{16'hFFFF}; sendUnit(q, 0, 0, 0);
    // R9 mode toggles before last
    q = '{16'h1234, 16'h4321, 16'hA5A5}; sendUnit(q, 0, 1, 1);
    q.push_back((~unitSum(q)) & 16'hFFFF); sendUnit(q, 1, 1, 1);

    // random units, random modes, gaps
    for (int u = 0; u < 60; u++) begin
      int len = $urandom_range(1, 9);
      q = {};
      for (int k = 0; k < len; k++) q.push_back($urandom_range(0, 65535));
      if (u % 2) begin
        q.push_back((~unitSum(q)) & 16'hFFFF);
        if (u % 4 == 3) q[0] = q[0] ^ 16'h0100;
        sendUnit(q, 1, u % 3 == 0, u % 5 == 0);
      end else sendUnit(q, 0, u % 3 == 0, u % 5 == 0);
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule